// File: doc/BRIEF.md
# Transmit Descriptor Ring Engine

This block moves outgoing frames from memory onto a byte stream, driven by a ring of three-word buffer descriptors that software fills in. The first word of a descriptor is a status word. The second word is the frame length in bytes. The third word is the word address of the frame buffer. Software queues a frame by writing the descriptor with the ready bit set and then pulsing `activate`. From that point the engine runs through consecutive ready descriptors on its own. For each one it streams the bytes out, hands the request for a CRC to the downstream MAC, and writes the status back with the ready bit cleared. It stops when it fetches a descriptor whose ready bit is already clear.

The ready bit is cleared in memory before the engine looks at any descriptor again. A ring of a single descriptor that carries both the wrap bit and the ready bit therefore sends its frame exactly once. A graceful stop request lets the frame in progress finish and then raises a sticky event, which is cleared with a write-one-to-clear strobe. Dropping the enable returns the ring position to the base address.

The memory is 16-bit wide and word addressed, with a read latency of one cycle. Buffer bytes leave high byte first.

Top module: `tx_desc_engine`

## Requirements
- R1: After reset, `mem_rd`, `mem_wr`, `tx_valid` and `stop_done` are all low.
- R2: An `activate` pulse while enabled and idle reads the status word at the current descriptor. If status bit 15 (ready) is clear, the engine returns to idle with no output byte and no memory write.
- R3: For a ready descriptor, exactly `length` bytes leave on `tx_data`, taken from consecutive buffer words, high byte first. `tx_sof` marks the first byte and `tx_eof` marks the last.
- R4: `tx_crc` equals status bit 10 of the descriptor on every byte of its frame.
- R5: After the last byte, the status word is written back to the descriptor address with bit 15 cleared and every other bit kept. The engine then fetches the next descriptor without a new `activate`.
- R6: After a write-back, the descriptor position advances by 3 words, or returns to `ring_base` when status bit 13 (wrap) is set.
- R7: A ring of one descriptor with both wrap and ready set is sent exactly once per queueing.
- R8: A ready descriptor of length zero produces no byte, but its ready bit is still cleared in memory.
- R9: If `stop_req` rises during a frame, the frame completes and is written back. `stop_done` then rises and no further descriptor is fetched.
- R10: If `stop_req` rises while the engine is idle, `stop_done` is set on the next edge. `activate` is ignored while stopped. Lowering `stop_req` returns the engine to idle.
- R11: An `evt_clr` pulse clears `stop_done`. When the event is set and cleared in the same cycle, the set wins.
- R12: While `en` is low the descriptor position is held at `ring_base`, and a frame in progress is abandoned with no further output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| en | input | 1 | Engine enable; low parks the ring at its base |
| ring_base | input | ADDR_W | Word address of the first descriptor |
| activate | input | 1 | One-cycle pulse that starts descriptor processing |
| stop_req | input | 1 | Graceful stop request (level) |
| evt_clr | input | 1 | Write-one-to-clear strobe for `stop_done` |
| stop_done | output | 1 | Sticky graceful-stop-complete event |
| mem_rd | output | 1 | Memory read strobe; data returns one cycle later |
| mem_wr | output | 1 | Memory write strobe |
| mem_addr | output | ADDR_W | Memory word address |
| mem_wdata | output | 16 | Memory write data (status write-back) |
| mem_rdata | input | 16 | Memory read data |
| tx_valid | output | 1 | Output byte valid |
| tx_data | output | 8 | Output byte |
| tx_sof | output | 1 | First byte of a frame |
| tx_eof | output | 1 | Last byte of a frame |
| tx_crc | output | 1 | Downstream should append a CRC to this frame |

## Verification
Two functions can land on the same edge: setting the stop event and the software clear of that event. The bench raises `stop_req` while the engine is idle and drives `evt_clr` in that same cycle. It then expects `stop_done` to read high, because the set wins, and a lone clear afterwards must bring it low. A second overlap is a stop request that arrives in the middle of a frame. There the scoreboard requires the whole frame and its write-back to appear before the event rises.

// File: rtl/tde_pkg.sv
// Shared definitions for the transmit descriptor ring engine.
// Assumes a 16-bit word-addressed memory; descriptors occupy three words.
package tde_pkg;

    localparam int unsigned WORD_W     = 16;
    localparam int unsigned DESC_WORDS = 3;

    // Offsets of the descriptor words.
    localparam int unsigned OFS_STATUS = 0;
    localparam int unsigned OFS_LEN    = 1;
    localparam int unsigned OFS_PTR    = 2;

    // Status word bit positions shared with software.
    localparam int unsigned BIT_READY = 15;
    localparam int unsigned BIT_WRAP  = 13;
    localparam int unsigned BIT_LAST  = 11;
    localparam int unsigned BIT_CRC   = 10;

    typedef enum logic [3:0] {
        S_IDLE,
        S_RD_ST,
        S_GET_ST,
        S_RD_LEN,
        S_GET_LEN,
        S_RD_PTR,
        S_GET_PTR,
        S_RD_DAT,
        S_EMIT_HI,
        S_EMIT_LO,
        S_WB,
        S_STOPPED
    } tde_state_e;

endpackage

// File: rtl/tde_ring_ptr.sv
// Descriptor position register for the transmit ring.
// Holds the word address of the current descriptor. Steps by one descriptor
// on each write-back, or returns to the base when the wrap bit is set.
// Assumes the base only changes while the engine is disabled.
module tde_ring_ptr #(
    parameter int unsigned ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic [ADDR_W-1:0] base,
    input  logic              advance,
    input  logic              wrap,
    output logic [ADDR_W-1:0] desc_addr
);
    import tde_pkg::*;

    localparam logic [ADDR_W-1:0] STEP = ADDR_W'(DESC_WORDS);

    logic [ADDR_W-1:0] pos_q;

    // Park at the base while disabled; otherwise step or wrap on write-back.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pos_q <= '0;
        end else if (!en) begin
            pos_q <= base;
        end else if (advance) begin
            pos_q <= wrap ? base : pos_q + STEP;
        end
    end

    assign desc_addr = pos_q;

    // R12: disable parks the position at the base.
    a_r12_park_at_base: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (desc_addr == $past(base)));

    // R6: a write-back of a wrap descriptor returns to the base.
    a_r6_wrap_to_base: assert property (@(posedge clk) disable iff (!rst_n)
        (en && advance && wrap) |=> (desc_addr == $past(base)));

    // R6: without wrap, the position moves by exactly one descriptor.
    a_r6_step_one: assert property (@(posedge clk) disable iff (!rst_n)
        (en && advance && !wrap) |=> (desc_addr == $past(desc_addr) + STEP));

endmodule

// File: rtl/tde_stop_evt.sv
// Sticky graceful-stop-complete event with write-one-to-clear.
// When a set and a clear arrive in the same cycle, the set wins.
module tde_stop_evt (
    input  logic clk,
    input  logic rst_n,
    input  logic set,
    input  logic clr,
    output logic evt
);
    logic evt_q;

    // Set has priority so that a completion is never lost to a clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            evt_q <= 1'b0;
        end else if (set) begin
            evt_q <= 1'b1;
        end else if (clr) begin
            evt_q <= 1'b0;
        end
    end

    assign evt = evt_q;

    // R11: the set wins over a clear in the same cycle.
    a_r11_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        set |=> evt);

    // R11: a clear alone drops the event.
    a_r11_clear_drops: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !set) |=> !evt);

    // R9: once raised, the event stays until cleared.
    a_r9_event_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (evt && !clr) |=> evt);

endmodule

// File: rtl/tde_ctrl.sv
// Sequencer of the transmit descriptor engine.
// Fetches status, length and pointer words, streams buffer bytes high byte
// first, writes the status back with ready cleared, and then fetches the next
// descriptor. Handles the graceful stop and the disable abort.
// Assumes a memory read latency of exactly one cycle and no stalls.
module tde_ctrl #(
    parameter int unsigned ADDR_W = 16,
    parameter int unsigned LEN_W  = 16
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       en,
    input  logic                       activate,
    input  logic                       stop_req,
    input  logic [ADDR_W-1:0]          desc_addr,
    output logic                       advance,
    output logic                       wrap,
    output logic                       stop_hit,
    output logic                       mem_rd,
    output logic                       mem_wr,
    output logic [ADDR_W-1:0]          mem_addr,
    output logic [tde_pkg::WORD_W-1:0] mem_wdata,
    input  logic [tde_pkg::WORD_W-1:0] mem_rdata,
    output logic                       tx_valid,
    output logic [7:0]                 tx_data,
    output logic                       tx_sof,
    output logic                       tx_eof,
    output logic                       tx_crc
);
    import tde_pkg::*;

    localparam logic [LEN_W-1:0]  LEN_ONE = LEN_W'(1);
    localparam logic [ADDR_W-1:0] A_LEN   = ADDR_W'(OFS_LEN);
    localparam logic [ADDR_W-1:0] A_PTR   = ADDR_W'(OFS_PTR);
    localparam logic [ADDR_W-1:0] A_ST    = ADDR_W'(OFS_STATUS);

    tde_state_e        state_q, state_d;
    logic [WORD_W-1:0] status_q;
    logic [LEN_W-1:0]  rem_q;
    logic [ADDR_W-1:0] ptr_q;
    logic [7:0]        lo_byte_q;
    logic              first_q;
    logic              last_byte;

    assign last_byte = (rem_q == LEN_ONE);

    // Next state, memory strobes and stream outputs for the current state.
    always_comb begin
        state_d   = state_q;
        advance   = 1'b0;
        wrap      = 1'b0;
        stop_hit  = 1'b0;
        mem_rd    = 1'b0;
        mem_wr    = 1'b0;
        mem_addr  = desc_addr + A_ST;
        mem_wdata = '0;
        tx_valid  = 1'b0;
        tx_data   = '0;
        tx_sof    = 1'b0;
        tx_eof    = 1'b0;
        tx_crc    = 1'b0;
        unique case (state_q)
            S_IDLE: begin
                if (en && stop_req) begin
                    state_d  = S_STOPPED;
                    stop_hit = 1'b1;
                end else if (en && activate) begin
                    state_d = S_RD_ST;
                end
            end
            S_RD_ST: begin
                mem_rd  = 1'b1;
                state_d = S_GET_ST;
            end
            S_GET_ST: begin
                state_d = mem_rdata[BIT_READY] ? S_RD_LEN : S_IDLE;
            end
            S_RD_LEN: begin
                mem_rd   = 1'b1;
                mem_addr = desc_addr + A_LEN;
                state_d  = S_GET_LEN;
            end
            S_GET_LEN: begin
                state_d = (mem_rdata[LEN_W-1:0] == '0) ? S_WB : S_RD_PTR;
            end
            S_RD_PTR: begin
                mem_rd   = 1'b1;
                mem_addr = desc_addr + A_PTR;
                state_d  = S_GET_PTR;
            end
            S_GET_PTR: begin
                state_d = S_RD_DAT;
            end
            S_RD_DAT: begin
                mem_rd   = 1'b1;
                mem_addr = ptr_q;
                state_d  = S_EMIT_HI;
            end
            S_EMIT_HI: begin
                tx_valid = 1'b1;
                tx_data  = mem_rdata[15:8];
                tx_sof   = first_q;
                tx_eof   = last_byte;
                tx_crc   = status_q[BIT_CRC];
                state_d  = last_byte ? S_WB : S_EMIT_LO;
            end
            S_EMIT_LO: begin
                tx_valid = 1'b1;
                tx_data  = lo_byte_q;
                tx_eof   = last_byte;
                tx_crc   = status_q[BIT_CRC];
                state_d  = last_byte ? S_WB : S_RD_DAT;
            end
            S_WB: begin
                mem_wr    = 1'b1;
                mem_wdata = status_q & ~(WORD_W'(1) << BIT_READY);
                advance   = 1'b1;
                wrap      = status_q[BIT_WRAP];
                if (stop_req) begin
                    state_d  = S_STOPPED;
                    stop_hit = 1'b1;
                end else begin
                    state_d = S_RD_ST;
                end
            end
            S_STOPPED: begin
                if (!stop_req) state_d = S_IDLE;
            end
            default: state_d = S_IDLE;
        endcase
        if (!en) begin
            state_d  = S_IDLE;
            stop_hit = 1'b0;
        end
    end

    // State register; a disable forces idle through state_d.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // Capture the descriptor fields and track the byte position of the frame.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            status_q  <= '0;
            rem_q     <= '0;
            ptr_q     <= '0;
            lo_byte_q <= '0;
            first_q   <= 1'b0;
        end else begin
            unique case (state_q)
                S_GET_ST:  status_q <= mem_rdata;
                S_GET_LEN: rem_q    <= mem_rdata[LEN_W-1:0];
                S_GET_PTR: begin
                    ptr_q   <= mem_rdata[ADDR_W-1:0];
                    first_q <= 1'b1;
                end
                S_RD_DAT:  ptr_q <= ptr_q + ADDR_W'(1);
                S_EMIT_HI: begin
                    lo_byte_q <= mem_rdata[7:0];
                    rem_q     <= rem_q - LEN_ONE;
                    first_q   <= 1'b0;
                end
                S_EMIT_LO: rem_q <= rem_q - LEN_ONE;
                default: ;
            endcase
        end
    end

    // R3: frame markers only travel with a valid byte.
    a_r3_marks_with_valid: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_sof || tx_eof) |-> tx_valid);

    // R5: the status write-back never leaves the ready bit set.
    a_r5_wb_clears_ready: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr |-> !mem_wdata[BIT_READY]);

    // R5: the last byte is followed directly by the write-back.
    a_r5_wb_after_last: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_eof && en) |=> mem_wr);

    // R5: a read and a write never share the memory port.
    a_r5_port_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd && mem_wr));

    // R9: once stopped, no descriptor is fetched while the request holds.
    a_r9_no_fetch_after_stop: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_hit && stop_req) |=> !mem_rd);

endmodule

// File: rtl/tx_desc_engine.sv
// Top level of the transmit descriptor ring engine.
// Connects the sequencer, the ring position register and the stop event.
// Assumes ADDR_W and the length field fit in one 16-bit memory word.
module tx_desc_engine #(
    parameter int unsigned ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic [ADDR_W-1:0] ring_base,
    input  logic              activate,
    input  logic              stop_req,
    input  logic              evt_clr,
    output logic              stop_done,
    output logic              mem_rd,
    output logic              mem_wr,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [15:0]       mem_wdata,
    input  logic [15:0]       mem_rdata,
    output logic              tx_valid,
    output logic [7:0]        tx_data,
    output logic              tx_sof,
    output logic              tx_eof,
    output logic              tx_crc
);
    localparam int unsigned LEN_W = tde_pkg::WORD_W;

    logic [ADDR_W-1:0] desc_addr;
    logic              advance;
    logic              wrap;
    logic              stop_hit;

    tde_ctrl #(
        .ADDR_W (ADDR_W),
        .LEN_W  (LEN_W)
    ) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (en),
        .activate  (activate),
        .stop_req  (stop_req),
        .desc_addr (desc_addr),
        .advance   (advance),
        .wrap      (wrap),
        .stop_hit  (stop_hit),
        .mem_rd    (mem_rd),
        .mem_wr    (mem_wr),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .mem_rdata (mem_rdata),
        .tx_valid  (tx_valid),
        .tx_data   (tx_data),
        .tx_sof    (tx_sof),
        .tx_eof    (tx_eof),
        .tx_crc    (tx_crc)
    );

    tde_ring_ptr #(
        .ADDR_W (ADDR_W)
    ) u_ring (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (en),
        .base      (ring_base),
        .advance   (advance),
        .wrap      (wrap),
        .desc_addr (desc_addr)
    );

    tde_stop_evt u_evt (
        .clk   (clk),
        .rst_n (rst_n),
        .set   (stop_hit),
        .clr   (evt_clr),
        .evt   (stop_done)
    );

    // R1: nothing moves while reset is held.
    a_r1_quiet_in_reset: assert property (@(posedge clk)
        !rst_n |=> (!mem_rd && !mem_wr && !tx_valid && !stop_done));

endmodule

// File: tb/tb_tx_desc_engine.sv
`timescale 1ns/1ps
module tb_tx_desc_engine;

    localparam int AW = 16;
    localparam logic [15:0] RDY  = 16'h8000;
    localparam logic [15:0] WRP  = 16'h2000;
    localparam logic [15:0] LST  = 16'h0800;
    localparam logic [15:0] CRCF = 16'h0400;

    typedef struct packed {
        logic [7:0] d;
        logic       sof;
        logic       eof;
        logic       crc;
    } exp_byte_t;

    typedef struct packed {
        logic [15:0] a;
        logic [15:0] d;
    } exp_wb_t;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic          rst_n = 1'b0;
    logic          en = 1'b0;
    logic [AW-1:0] ring_base = '0;
    logic          activate = 1'b0;
    logic          stop_req = 1'b0;
    logic          evt_clr = 1'b0;
    logic          stop_done;
    logic          mem_rd, mem_wr;
    logic [AW-1:0] mem_addr;
    logic [15:0]   mem_wdata;
    logic [15:0]   mem_rdata = '0;
    logic          tx_valid;
    logic [7:0]    tx_data;
    logic          tx_sof, tx_eof, tx_crc;

    tx_desc_engine #(.ADDR_W(AW)) dut (
        .clk(clk), .rst_n(rst_n), .en(en), .ring_base(ring_base),
        .activate(activate), .stop_req(stop_req), .evt_clr(evt_clr),
        .stop_done(stop_done), .mem_rd(mem_rd), .mem_wr(mem_wr),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .tx_valid(tx_valid), .tx_data(tx_data), .tx_sof(tx_sof),
        .tx_eof(tx_eof), .tx_crc(tx_crc)
    );

    // Memory model: one-cycle read latency, bench pokes share the write port.
    logic [15:0] mem [0:255];
    logic        poke_en = 1'b0;
    logic [7:0]  poke_a = '0;
    logic [15:0] poke_d = '0;
    always @(posedge clk) begin
        if (mem_rd) mem_rdata <= mem[mem_addr[7:0]];
        if (mem_wr) mem[mem_addr[7:0]] <= mem_wdata;
        else if (poke_en) mem[poke_a] <= poke_d;
    end

    exp_byte_t byte_q[$];
    exp_wb_t   wb_q[$];
    int checks = 0, fails = 0;
    int mchecks = 0, mfails = 0;
    int n_bytes = 0, n_wr = 0, raw_valid = 0;
    logic [15:0] last_rd = '0;
    bit mon_off = 1'b0;
    bit done = 1'b0;

    // Monitor: pops expected bytes and write-backs and compares them.
    always @(negedge clk) begin
        if (rst_n) begin
            if (mem_rd) last_rd = mem_addr;
            if (tx_valid) raw_valid++;
            if (tx_valid && !mon_off) begin
                n_bytes++;
                if (byte_q.size() == 0) begin
                    mchecks++; mfails++;
                    $display("FAIL R3 unexpected byte act=%02h exp=none", tx_data);
                end else begin
                    exp_byte_t e;
                    e = byte_q.pop_front();
                    mchecks++;
                    if ({tx_data, tx_sof, tx_eof} !== {e.d, e.sof, e.eof}) begin
                        mfails++;
                        $display("FAIL R3 byte/sof/eof act=%02h/%0b/%0b exp=%02h/%0b/%0b",
                                 tx_data, tx_sof, tx_eof, e.d, e.sof, e.eof);
                    end
                    mchecks++;
                    if (tx_crc !== e.crc) begin
                        mfails++;
                        $display("FAIL R4 crc flag act=%0b exp=%0b", tx_crc, e.crc);
                    end
                end
            end
            if (mem_wr && !mon_off) begin
                n_wr++;
                mchecks++;
                if (wb_q.size() == 0) begin
                    mfails++;
                    $display("FAIL R5 unexpected write act=%04h:%04h exp=none", mem_addr, mem_wdata);
                end else begin
                    exp_wb_t w;
                    w = wb_q.pop_front();
                    if ({mem_addr, mem_wdata} !== {w.a, w.d}) begin
                        mfails++;
                        $display("FAIL R5 write-back act=%04h:%04h exp=%04h:%04h",
                                 mem_addr, mem_wdata, w.a, w.d);
                    end
                end
            end
        end
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    task automatic poke(input int a, input logic [15:0] d);
        poke_en = 1'b1; poke_a = a[7:0]; poke_d = d;
        tick(1);
        poke_en = 1'b0;
    endtask

    task automatic set_desc(input int a, input logic [15:0] st, input int len, input int ptr);
        poke(a, st);
        poke(a + 1, len[15:0]);
        poke(a + 2, ptr[15:0]);
    endtask

    // Driver: fills a buffer and queues the bytes and the write-back expected.
    task automatic queue_frame(input int da, input logic [15:0] st, input int len,
                               input int ptr, input int seed);
        set_desc(da, st, len, ptr);
        for (int i = 0; i < (len + 1) / 2; i++) begin
            logic [7:0] hi, lo;
            hi = 8'(seed + 2 * i);
            lo = 8'(seed + 2 * i + 1);
            poke(ptr + i, {hi, lo});
        end
        for (int j = 0; j < len; j++) begin
            exp_byte_t e;
            e.d = 8'(seed + j);
            e.sof = (j == 0);
            e.eof = (j == len - 1);
            e.crc = st[10];
            byte_q.push_back(e);
        end
        wb_q.push_back({16'(da), st & 16'h7FFF});
    endtask

    task automatic pulse_act();
        activate = 1'b1; tick(1); activate = 1'b0;
    endtask

    task automatic finish_run(input int extra);
        $display("TB_RESULT checks=%0d failures=%0d",
                 checks + mchecks + extra, fails + mfails + extra);
        $finish;
    endtask

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            $display("FAIL watchdog act=timeout exp=finish");
            finish_run(1);
        end
    end

    initial begin
        int n0, w0, r0;
        tick(3);
        rst_n = 1'b1;
        tick(1);
        // R1: reset state
        chk(!mem_rd && !mem_wr, "R1 memory idle", {mem_rd, mem_wr}, 0);
        chk(!tx_valid, "R1 stream idle", tx_valid, 0);
        chk(!stop_done, "R1 event clear", stop_done, 0);

        ring_base = 16'h10; tick(1); en = 1'b1;

        // R2: not-ready descriptor fetched at the base, then idle
        poke(16'h10, 16'h0000);
        pulse_act(); tick(10);
        chk(last_rd == 16'h10, "R2 status fetch address", last_rd, 16'h10);
        chk(n_bytes == 0 && n_wr == 0, "R2 no output for not-ready", n_bytes + n_wr, 0);

        // R3 R4 R5: two chained frames, odd and even length, crc on then off
        queue_frame(16'h10, RDY | LST | CRCF, 5, 16'h40, 8'hA0);
        queue_frame(16'h13, RDY | LST, 4, 16'h50, 8'hB0);
        poke(16'h16, 16'h0000);
        pulse_act(); tick(80);
        chk(byte_q.size() == 0, "R3 all bytes seen", byte_q.size(), 0);
        chk(n_bytes == 9, "R3 byte count", n_bytes, 9);
        chk(wb_q.size() == 0, "R5 chained write-backs", wb_q.size(), 0);
        chk(mem[8'h10] == (LST | CRCF), "R5 status kept with ready cleared", mem[8'h10], LST | CRCF);

        // R6: wrap descriptor returns to the base, then stops at cleared 0x13
        queue_frame(16'h16, RDY | WRP | LST, 2, 16'h60, 8'hC0);
        queue_frame(16'h10, RDY | LST, 1, 16'h70, 8'hD0);
        pulse_act(); tick(80);
        chk(byte_q.size() == 0 && wb_q.size() == 0, "R6 wrap to base",
            byte_q.size() + wb_q.size(), 0);
        chk(last_rd == 16'h13, "R6 step after base", last_rd, 16'h13);

        // R12 R7: disable moves position to new base; single wrap ring sends once
        en = 1'b0; ring_base = 16'h20; tick(2); en = 1'b1;
        queue_frame(16'h20, RDY | WRP | LST | CRCF, 3, 16'h80, 8'h10);
        n0 = n_bytes; w0 = n_wr;
        pulse_act(); tick(60);
        chk(n_bytes - n0 == 3, "R7 single descriptor sent once", n_bytes - n0, 3);
        chk(n_wr - w0 == 1, "R7 one write-back", n_wr - w0, 1);
        chk(byte_q.size() == 0, "R12 fetch from new base", byte_q.size(), 0);

        // R8: zero length descriptor
        set_desc(16'h20, RDY | WRP, 0, 16'h80);
        wb_q.push_back({16'h20, WRP});
        n0 = n_bytes;
        pulse_act(); tick(30);
        chk(n_bytes == n0, "R8 no bytes for zero length", n_bytes - n0, 0);
        chk(mem[8'h20] == WRP, "R8 ready cleared", mem[8'h20], WRP);

        // R9: stop during a frame
        queue_frame(16'h20, RDY | WRP | LST, 6, 16'h90, 8'h30);
        pulse_act(); tick(8);
        stop_req = 1'b1;
        chk(!stop_done, "R9 no event mid-frame", stop_done, 0);
        tick(40);
        chk(byte_q.size() == 0 && wb_q.size() == 0, "R9 frame completed",
            byte_q.size() + wb_q.size(), 0);
        chk(stop_done, "R9 event after frame", stop_done, 1);

        // R11: plain clear
        evt_clr = 1'b1; tick(1); evt_clr = 1'b0;
        chk(!stop_done, "R11 clear", stop_done, 0);

        // R10: activate ignored while stopped
        set_desc(16'h20, RDY | WRP | LST, 2, 16'hA0);
        n0 = n_bytes;
        pulse_act(); tick(20);
        chk(n_bytes == n0, "R10 activate ignored while stopped", n_bytes - n0, 0);
        chk(mem[8'h20][15], "R10 descriptor untouched", mem[8'h20], RDY | WRP | LST);
        stop_req = 1'b0; tick(2);
        queue_frame(16'h20, RDY | WRP | LST, 2, 16'hA0, 8'h50);
        pulse_act(); tick(30);
        chk(byte_q.size() == 0, "R10 resumes after release", byte_q.size(), 0);

        // R10: stop while idle sets the event on the next edge
        stop_req = 1'b1; tick(1);
        chk(stop_done, "R10 idle stop event", stop_done, 1);
        evt_clr = 1'b1; tick(1); evt_clr = 1'b0;
        chk(!stop_done, "R11 clear while stopped", stop_done, 0);
        stop_req = 1'b0; tick(2);

        // R11: set and clear in the same cycle
        stop_req = 1'b1; evt_clr = 1'b1; tick(1); evt_clr = 1'b0;
        chk(stop_done, "R11 set wins over clear", stop_done, 1);
        evt_clr = 1'b1; tick(1); evt_clr = 1'b0;
        chk(!stop_done, "R11 clear after collision", stop_done, 0);
        stop_req = 1'b0; tick(2);

        // R12: disable abandons a frame in progress
        set_desc(16'h20, RDY | WRP | LST, 20, 16'hB0);
        mon_off = 1'b1;
        pulse_act(); tick(12);
        en = 1'b0; tick(1);
        r0 = raw_valid; tick(10);
        chk(raw_valid == r0, "R12 no output after disable", raw_valid - r0, 0);
        mon_off = 1'b0; en = 1'b1; tick(1);
        queue_frame(16'h20, RDY | WRP | LST, 20, 16'hB0, 8'h70);
        pulse_act(); tick(80);
        chk(byte_q.size() == 0 && wb_q.size() == 0, "R12 full resend from base",
            byte_q.size() + wb_q.size(), 0);

        done = 1'b1;
        finish_run(0);
    end

endmodule